// File: doc/BRIEF.md
# CAN Receive Drain Bridge

This block joins a byte-wide host bus to the register port of one CAN controller. Nearly every host address in the channel window goes straight through to the controller with the same offset, data and direction. The two highest addresses of the window stay inside the bridge. The second highest is a data port onto a receive FIFO. The highest is a channel configuration and status byte.

When draining is switched on, a small engine takes action whenever the controller raises its interrupt. It reads the controller's status register. If a received message is waiting, it reads the frame info byte and works out how many bytes the message holds. It waits until the FIFO has room for all of them, copies them into the FIFO in order, and then writes the release command to the controller. The host then takes whole messages from the FIFO data port and no longer reads the controller's receive buffer. When draining is off, the engine makes no controller accesses and the host reads messages from the controller directly.

The configuration byte also reports whether the FIFO is empty or at least half full. It shows the state of this controller's interrupt and of the interrupts of the eight channels taken together. The same combined interrupt drives the host's active-low interrupt line. A system places eight of these channels 0x1000 apart; decoding the channel is done outside this block.

Top module: `canrx_dma_bridge`

## Requirements
- R1: After reset, drain enable is 0, the configuration byte reads 0x10 with no interrupt inputs active, `hst_ack` is low and `host_irq_n` is high.
- R2: A host access to any offset below 0xFE is issued on the controller bus with the same offset, direction and write data. A read returns the controller's data. The access completes with a single-cycle `hst_ack` two cycles after the request is seen. Accesses to 0xFE and 0xFF are acknowledged after one cycle.
- R3: The configuration byte at offset 0xFF is laid out as follows. Bit 0 is drain enable and can be read and written. Bit 4 is FIFO empty, bit 5 is FIFO half full, bit 6 is this controller's interrupt active, and bit 7 is any interrupt active. Bits 1 to 3 read 0. Writes to bits 7:1 have no effect.
- R4: While drain enable is 0, a controller interrupt causes no controller bus access, the message stays in the controller for the host to read, and the FIFO stays empty.
- R5: While drain enable is 1 and the interrupt is active, the engine reads status offset 2. If bit 0 is set, it reads the frame info byte at offset 16. The byte count is 3+DLC when info bit 7 is 0 and 5+DLC when it is 1, where DLC is info bits 3:0 limited to 8. The engine copies offsets 16 onward in rising order into the FIFO and then writes 0x04 to offset 1. This takes exactly count+2 controller accesses.
- R6: A read of offset 0xFE returns the oldest FIFO byte and removes it. On an empty FIFO the read returns 0 and changes nothing. A write to 0xFE is ignored.
- R7: The FIFO empty flag is 1 exactly when the FIFO holds 0 bytes. The half-full flag is 1 exactly when it holds at least DEPTH/2 bytes (16 by default).
- R8: Bit 6 follows `ctl_irq_n` inverted. Bit 7 and a low `host_irq_n` are active when this controller or any of the seven peer interrupt inputs (active low) is active.
- R9: When the FIFO has less free space than the message's byte count, the engine copies nothing and does not release the message until space appears. Host accesses to 0xFE and 0xFF are still served during the wait.
- R10: A host controller access that arrives during a transfer is held until the release write has been issued. When a host access and a new interrupt are pending together, the host access goes first.
- R11: The FIFO is never written while full. A message that exactly fills the FIFO is stored whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_req | input | 1 | Host access request, held until acknowledged |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_addr | input | ADDR_W | Offset within the channel window |
| hst_wdata | input | 8 | Host write data |
| hst_ack | output | 1 | Single-cycle completion pulse |
| hst_rdata | output | 8 | Read data, valid with `hst_ack` |
| host_irq_n | output | 1 | Combined interrupt, active low |
| ctl_en | output | 1 | Controller bus access strobe |
| ctl_we | output | 1 | Controller bus write |
| ctl_addr | output | ADDR_W | Controller register offset |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data, one cycle after a read strobe |
| ctl_irq_n | input | 1 | This controller's interrupt, active low |
| peer_irq_n | input | PEERS | Interrupts of the other channels, active low |

## Verification
On every cycle the assertions check four things. The FIFO is never written while full, and its fill count follows pushes and pops exactly. The acknowledge is a single pulse. With draining off, the idle engine starts no controller access of its own. An active controller interrupt always pulls the host line low. What only the bench's scenarios can show is the following. Each byte count is worked out correctly over every DLC and both identifier formats, and nothing extra is copied. A message that does not fit is held whole and later released. The half-full and empty flags change at the exact fill levels. A host access that meets a transfer in progress is ordered correctly against the release write.

// File: rtl/canrx_pkg.sv
// Shared constants and types of the CAN receive drain bridge.
// Assumes a controller whose receive buffer starts at offset 16, whose status
// register sits at offset 2 (bit 0 = message waiting) and whose command
// register at offset 1 releases the buffer when bit 2 is written as 1.
package canrx_pkg;

    localparam int RX_BASE    = 16;
    localparam int STAT_OFS   = 2;
    localparam int CMD_OFS    = 1;
    localparam int RBS_BIT    = 0;
    localparam logic [7:0] REL_CMD = 8'h04;
    localparam int FF_BIT     = 7;
    localparam int MAX_DATA   = 8;
    localparam int STD_ID_B   = 2;
    localparam int EXT_ID_B   = 4;
    localparam int LEN_W      = 4;

    // configuration byte bit positions
    localparam int CFG_EN     = 0;
    localparam int CFG_EMPTY  = 4;
    localparam int CFG_HALF   = 5;
    localparam int CFG_CIRQ   = 6;
    localparam int CFG_AIRQ   = 7;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_HOST,
        ENG_STAT,
        ENG_INFO,
        ENG_FIT,
        ENG_DATA
    } eng_state_t;

    // Total bytes of a received message: info byte, identifier bytes, data.
    function automatic logic [LEN_W-1:0] frame_bytes(input logic ext, input logic [3:0] dlc);
        logic [LEN_W-1:0] dbytes;
        logic [LEN_W-1:0] idb;
        dbytes = (dlc > 4'(MAX_DATA)) ? LEN_W'(MAX_DATA) : dlc;
        idb    = ext ? LEN_W'(EXT_ID_B) : LEN_W'(STD_ID_B);
        return LEN_W'(1) + idb + dbytes;
    endfunction

endpackage

// File: rtl/canrx_fifo.sv
// Byte FIFO that holds drained messages.
// Assumes DEPTH is a power of two; push and pop may occur in the same cycle.
// Callers never push while full or pop while empty.
module canrx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic [CW-1:0] free
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    // storage write on push
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    // pointer and fill count bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            if (pop)  rptr <= rptr + AW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rptr];
    assign free = CW'(DEPTH) - count;

endmodule

// File: rtl/canrx_dma_engine.sv
// Controller bus owner: issues host pass-through accesses and runs the
// receive drain sequence (status poll, info read, fit wait, byte copy,
// release write). Host accesses are taken only in the idle state, so a
// transfer is never interrupted. Assumes controller read data arrives
// exactly one cycle after a read strobe.
module canrx_dma_engine
    import canrx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              irq_act,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic [7:0]        ctl_rdata,
    input  logic [CW-1:0]     fifo_free,
    output logic              ctl_en,
    output logic              ctl_we,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic [7:0]        ctl_wdata,
    output logic              fifo_push,
    output logic [7:0]        fifo_data,
    output logic              host_done,
    output logic              idle
);

    eng_state_t       state;
    eng_state_t       nxt;
    logic [7:0]       info_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;

    // next state and controller bus / FIFO strobes
    always_comb begin
        nxt       = state;
        ctl_en    = 1'b0;
        ctl_we    = 1'b0;
        ctl_addr  = '0;
        ctl_wdata = '0;
        fifo_push = 1'b0;
        fifo_data = '0;
        host_done = 1'b0;
        case (state)
            ENG_IDLE: begin
                if (host_req) begin
                    ctl_en    = 1'b1;
                    ctl_we    = host_we;
                    ctl_addr  = host_addr;
                    ctl_wdata = host_wdata;
                    nxt       = ENG_HOST;
                end else if (dma_en && irq_act) begin
                    ctl_en   = 1'b1;
                    ctl_addr = ADDR_W'(STAT_OFS);
                    nxt      = ENG_STAT;
                end
            end
            ENG_HOST: begin
                host_done = 1'b1;
                nxt       = ENG_IDLE;
            end
            ENG_STAT: begin
                if (ctl_rdata[RBS_BIT]) begin
                    ctl_en   = 1'b1;
                    ctl_addr = ADDR_W'(RX_BASE);
                    nxt      = ENG_INFO;
                end else begin
                    nxt = ENG_IDLE;
                end
            end
            ENG_INFO: begin
                nxt = ENG_FIT;
            end
            ENG_FIT: begin
                if (fifo_free >= CW'(len_q)) begin
                    fifo_push = 1'b1;
                    fifo_data = info_q;
                    ctl_en    = 1'b1;
                    ctl_addr  = ADDR_W'(RX_BASE + 1);
                    nxt       = ENG_DATA;
                end
            end
            ENG_DATA: begin
                fifo_push = 1'b1;
                fifo_data = ctl_rdata;
                ctl_en    = 1'b1;
                if (idx_q == len_q - LEN_W'(1)) begin
                    ctl_we    = 1'b1;
                    ctl_addr  = ADDR_W'(CMD_OFS);
                    ctl_wdata = REL_CMD;
                    nxt       = ENG_IDLE;
                end else begin
                    ctl_addr = ADDR_W'(RX_BASE) + ADDR_W'(idx_q) + ADDR_W'(1);
                end
            end
            default: nxt = ENG_IDLE;
        endcase
    end

    // state register and message bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            info_q <= '0;
            len_q  <= '0;
            idx_q  <= '0;
        end else begin
            state <= nxt;
            if (state == ENG_INFO) begin
                info_q <= ctl_rdata;
                len_q  <= frame_bytes(ctl_rdata[FF_BIT], ctl_rdata[3:0]);
            end
            if (state == ENG_FIT)  idx_q <= LEN_W'(1);
            if (state == ENG_DATA) idx_q <= idx_q + LEN_W'(1);
        end
    end

    assign idle = (state == ENG_IDLE);

endmodule

// File: rtl/canrx_host_port.sv
// Host side decode: serves the FIFO data port and configuration byte
// locally, forwards every other offset to the engine, and returns the single
// acknowledge pulse. Assumes the host holds a request until acknowledged and
// drops or changes it while the acknowledge is high.
module canrx_host_port
    import canrx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 32,
    parameter int CW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_req,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              cfg_wbit,
    output logic              hst_ack,
    output logic [7:0]        hst_rdata,
    output logic              ctl_req,
    input  logic              eng_done,
    input  logic [7:0]        ctl_rdata,
    input  logic [7:0]        fifo_head,
    input  logic [CW-1:0]     fifo_count,
    output logic              fifo_pop,
    output logic              dma_en,
    input  logic              ctl_irq_act,
    input  logic              any_irq_act
);

    localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'((1 << ADDR_W) - 2);
    localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'((1 << ADDR_W) - 1);

    logic       live;
    logic       is_port;
    logic       is_cfg;
    logic       fifo_empty;
    logic       fifo_half;
    logic [7:0] status;

    // request decode and local status byte
    always_comb begin
        live       = hst_req && !hst_ack;
        is_port    = (hst_addr == PORT_ADDR);
        is_cfg     = (hst_addr == CFG_ADDR);
        ctl_req    = live && !is_port && !is_cfg;
        fifo_empty = (fifo_count == '0);
        fifo_half  = (fifo_count >= CW'(DEPTH / 2));
        fifo_pop   = live && is_port && !hst_we && !fifo_empty;
        status            = '0;
        status[CFG_EN]    = dma_en;
        status[CFG_EMPTY] = fifo_empty;
        status[CFG_HALF]  = fifo_half;
        status[CFG_CIRQ]  = ctl_irq_act;
        status[CFG_AIRQ]  = any_irq_act;
    end

    // acknowledge, read data and drain enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_ack   <= 1'b0;
            hst_rdata <= '0;
            dma_en    <= 1'b0;
        end else begin
            hst_ack <= (live && (is_port || is_cfg)) || eng_done;
            if (eng_done) begin
                hst_rdata <= ctl_rdata;
            end else if (live && !hst_we && is_port) begin
                hst_rdata <= fifo_empty ? 8'h00 : fifo_head;
            end else if (live && !hst_we && is_cfg) begin
                hst_rdata <= status;
            end
            if (live && hst_we && is_cfg) dma_en <= cfg_wbit;
        end
    end

endmodule

// File: rtl/canrx_dma_bridge.sv
// Top of one CAN receive drain channel: host decode, controller bus engine,
// receive FIFO and interrupt merge. Assumes the channel select has already
// been decoded by the system and that peer interrupts come from the other
// channels of the group.
module canrx_dma_bridge
    import canrx_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 32,
    parameter int PEERS      = 7,
    localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_req,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [7:0]        hst_wdata,
    output logic              hst_ack,
    output logic [7:0]        hst_rdata,
    output logic              host_irq_n,
    output logic              ctl_en,
    output logic              ctl_we,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic [7:0]        ctl_wdata,
    input  logic [7:0]        ctl_rdata,
    input  logic              ctl_irq_n,
    input  logic [PEERS-1:0]  peer_irq_n
);

    logic          host_ctl_req;
    logic          eng_done;
    logic          eng_idle;
    logic          dma_en;
    logic          fifo_push;
    logic          fifo_pop;
    logic [7:0]    fifo_wdata;
    logic [7:0]    fifo_head;
    logic [CW-1:0] fifo_count;
    logic [CW-1:0] fifo_free;
    logic          ctl_irq_act;
    logic          any_irq_act;

    // interrupt merge of this controller and its peers
    always_comb begin
        ctl_irq_act = !ctl_irq_n;
        any_irq_act = ctl_irq_act || !(&peer_irq_n);
        host_irq_n  = !any_irq_act;
    end

    canrx_host_port #(
        .ADDR_W(ADDR_W),
        .DEPTH (FIFO_DEPTH),
        .CW    (CW)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .hst_req    (hst_req),
        .hst_we     (hst_we),
        .hst_addr   (hst_addr),
        .cfg_wbit   (hst_wdata[CFG_EN]),
        .hst_ack    (hst_ack),
        .hst_rdata  (hst_rdata),
        .ctl_req    (host_ctl_req),
        .eng_done   (eng_done),
        .ctl_rdata  (ctl_rdata),
        .fifo_head  (fifo_head),
        .fifo_count (fifo_count),
        .fifo_pop   (fifo_pop),
        .dma_en     (dma_en),
        .ctl_irq_act(ctl_irq_act),
        .any_irq_act(any_irq_act)
    );

    canrx_dma_engine #(
        .ADDR_W(ADDR_W),
        .CW    (CW)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_en    (dma_en),
        .irq_act   (ctl_irq_act),
        .host_req  (host_ctl_req),
        .host_we   (hst_we),
        .host_addr (hst_addr),
        .host_wdata(hst_wdata),
        .ctl_rdata (ctl_rdata),
        .fifo_free (fifo_free),
        .ctl_en    (ctl_en),
        .ctl_we    (ctl_we),
        .ctl_addr  (ctl_addr),
        .ctl_wdata (ctl_wdata),
        .fifo_push (fifo_push),
        .fifo_data (fifo_wdata),
        .host_done (eng_done),
        .idle      (eng_idle)
    );

    canrx_fifo #(
        .DW   (8),
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fifo_push),
        .push_data(fifo_wdata),
        .pop      (fifo_pop),
        .head     (fifo_head),
        .count    (fifo_count),
        .free     (fifo_free)
    );

endmodule

// File: rtl/canrx_bridge_checker.sv
// Cycle-by-cycle properties of the receive drain channel, attached to the
// top module by the bind below.
module canrx_bridge_checker #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hst_ack,
    input logic          ctl_en,
    input logic          ctl_irq_n,
    input logic          host_irq_n,
    input logic          fifo_push,
    input logic          fifo_pop,
    input logic [CW-1:0] fifo_count,
    input logic          eng_idle,
    input logic          host_ctl_req,
    input logic          dma_en
);

    // R11: no byte is written into a full FIFO
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (fifo_count < CW'(DEPTH)));

    // R7: fill level moves by exactly the pushes and pops of the cycle before
    assert_fill_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fifo_count == $past(fifo_count) + CW'($past(fifo_push)) - CW'($past(fifo_pop))));

    // R2: every acknowledge lasts one cycle
    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ack |=> !hst_ack);

    // R4: an idle engine starts no access of its own while draining is off
    assert_quiet_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_idle && ctl_en && !host_ctl_req) |-> dma_en);

    // R8: an active controller interrupt always reaches the host line
    assert_irq_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_irq_n |-> !host_irq_n);

endmodule

bind canrx_dma_bridge canrx_bridge_checker #(
    .DEPTH(FIFO_DEPTH),
    .CW   (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hst_ack     (hst_ack),
    .ctl_en      (ctl_en),
    .ctl_irq_n   (ctl_irq_n),
    .host_irq_n  (host_irq_n),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop),
    .fifo_count  (fifo_count),
    .eng_idle    (eng_idle),
    .host_ctl_req(host_ctl_req),
    .dma_en      (dma_en)
);

// File: tb/tb_canrx_dma_bridge.sv
module tb_canrx_dma_bridge;

    localparam int AW    = 8;
    localparam int DEPTH = 32;
    localparam int NP    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hst_req = 1'b0;
    logic          hst_we = 1'b0;
    logic [AW-1:0] hst_addr = '0;
    logic [7:0]    hst_wdata = '0;
    logic          hst_ack;
    logic [7:0]    hst_rdata;
    logic          host_irq_n;
    logic          ctl_en;
    logic          ctl_we;
    logic [AW-1:0] ctl_addr;
    logic [7:0]    ctl_wdata;
    logic [7:0]    ctl_rdata = '0;
    logic          ctl_irq_n;
    logic [NP-1:0] peer_irq_n = '1;

    int total = 0;
    int bad = 0;

    // controller model state
    logic [7:0] cmem [256];
    bit         pending = 1'b0;
    int         rel_cnt = 0;
    int         acc_cnt = 0;
    bit         arm = 1'b0;
    int         first_addr = -1;

    always #2 clk = ~clk;

    canrx_dma_bridge #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH), .PEERS(NP)) dut (
        .clk(clk), .rst_n(rst_n),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_ack(hst_ack), .hst_rdata(hst_rdata), .host_irq_n(host_irq_n),
        .ctl_en(ctl_en), .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .ctl_irq_n(ctl_irq_n), .peer_irq_n(peer_irq_n)
    );

    assign ctl_irq_n = !pending;

    // controller register model with one-cycle read latency
    always @(posedge clk) begin
        if (ctl_en) begin
            acc_cnt = acc_cnt + 1;
            if (arm) begin
                first_addr = int'(ctl_addr);
                arm = 1'b0;
            end
            if (ctl_we) begin
                if (ctl_addr == 8'd1 && ctl_wdata[2]) begin
                    pending = 1'b0;
                    rel_cnt = rel_cnt + 1;
                end else begin
                    cmem[ctl_addr] = ctl_wdata;
                end
            end else begin
                ctl_rdata <= (ctl_addr == 8'd2) ? {7'b0, pending} : cmem[ctl_addr];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_acc(input bit we, input logic [7:0] a, input logic [7:0] d,
                            input bit raise_irq, output logic [7:0] q, output int lat);
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = d;
        if (raise_irq) begin
            arm = 1'b1;
            pending = 1'b1;
        end
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!hst_ack && lat < 2000);
        q = hst_rdata;
        hst_req = 1'b0; hst_we = 1'b0;
    endtask

    function automatic int exp_len(input logic [7:0] info);
        int d;
        d = (int'(info[3:0]) > 8) ? 8 : int'(info[3:0]);
        return 1 + (info[7] ? 4 : 2) + d;
    endfunction

    function automatic logic [7:0] msg_byte(input int k, input int j, input logic [7:0] info);
        return (j == 0) ? info : 8'(k * 37 + j * 5 + 3);
    endfunction

    task automatic load_msg(input int k, input logic [7:0] info);
        for (int j = 0; j < 13; j++) cmem[RXB(j)] = msg_byte(k, j, info);
    endtask

    function automatic int RXB(input int j);
        return 16 + j;
    endfunction

    task automatic wait_release(input int prev);
        int n;
        n = 0;
        while (rel_cnt == prev && n < 500) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic drain_check(input int k, input logic [7:0] info, input string tag);
        logic [7:0] q;
        int lat;
        for (int j = 0; j < exp_len(info); j++) begin
            host_acc(1'b0, 8'hFE, 8'h00, 1'b0, q, lat);
            chk(tag, int'(q), int'(msg_byte(k, j, info)));
        end
        host_acc(1'b0, 8'hFE, 8'h00, 1'b0, q, lat);
        chk({tag, " empty port reads 0 (R6)"}, int'(q), 0);
        host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
        chk({tag, " empty after drain (R7)"}, int'(q[4]), 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] q;
        int lat;
        int prev;
        int acc0;
        logic [7:0] info;
        logic [7:0] seq [32];
        int ns;

        for (int i = 0; i < 256; i++) cmem[i] = 8'(i ^ 8'h5A);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 ack low", int'(hst_ack), 0);
        chk("R1 host irq high", int'(host_irq_n), 1);
        chk("R1 controller bus idle", int'(ctl_en), 0);
        host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
        chk("R1 config reset value", int'(q), 'h10);
        chk("R2 local ack latency", lat, 1);

        // R2: pass-through of writes and reads, including the highest offset
        host_acc(1'b1, 8'd5, 8'hA5, 1'b0, q, lat);
        chk("R2 write reaches controller", int'(cmem[5]), 'hA5);
        chk("R2 write latency", lat, 2);
        host_acc(1'b0, 8'd5, 8'h00, 1'b0, q, lat);
        chk("R2 read data", int'(q), 'hA5);
        chk("R2 read latency", lat, 2);
        host_acc(1'b1, 8'hFD, 8'h3E, 1'b0, q, lat);
        chk("R2 top controller offset", int'(cmem[253]), 'h3E);

        // R3: configuration layout, read-only bits unaffected
        host_acc(1'b1, 8'hFF, 8'hFF, 1'b0, q, lat);
        host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
        chk("R3 enable set, ro bits kept", int'(q), 'h11);
        host_acc(1'b1, 8'hFF, 8'hFE, 1'b0, q, lat);
        host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
        chk("R3 enable cleared", int'(q), 'h10);

        // R6: empty port read and ignored write
        host_acc(1'b1, 8'hFE, 8'h55, 1'b0, q, lat);
        host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
        chk("R6 port write ignored", int'(q), 'h10);
        host_acc(1'b0, 8'hFE, 8'h00, 1'b0, q, lat);
        chk("R6 empty port read", int'(q), 0);

        // R4 / R8: draining off, message left in controller
        info = 8'h05;
        load_msg(99, info);
        acc0 = acc_cnt;
        @(negedge clk);
        pending = 1'b1;
        repeat (30) @(negedge clk);
        chk("R4 no engine accesses", acc_cnt - acc0, 0);
        chk("R8 host irq low", int'(host_irq_n), 0);
        host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
        chk("R4 R8 config with irq, fifo empty", int'(q), 'hD0);
        host_acc(1'b0, 8'd16, 8'h00, 1'b0, q, lat);
        chk("R4 host reads info directly", int'(q), int'(info));
        prev = rel_cnt;
        host_acc(1'b1, 8'd1, 8'h04, 1'b0, q, lat);
        chk("R4 host release", rel_cnt - prev, 1);

        // R8: each peer interrupt alone
        for (int p = 0; p < NP; p++) begin
            @(negedge clk);
            peer_irq_n = ~(NP'(1) << p);
            host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
            chk("R8 peer sets any-irq only", int'(q), 'h90);
            chk("R8 peer drives host line", int'(host_irq_n), 0);
        end
        @(negedge clk);
        peer_irq_n = '1;
        @(negedge clk);
        chk("R8 host line released", int'(host_irq_n), 1);

        // R5: sweep over both formats and every DLC
        host_acc(1'b1, 8'hFF, 8'h01, 1'b0, q, lat);
        for (int ext = 0; ext < 2; ext++) begin
            for (int dlc = 0; dlc < 16; dlc++) begin
                int k;
                k = ext * 16 + dlc;
                info = {ext[0], 3'(dlc), 4'(dlc)};
                load_msg(k, info);
                prev = rel_cnt;
                acc0 = acc_cnt;
                @(negedge clk);
                pending = 1'b1;
                wait_release(prev);
                chk("R5 one release", rel_cnt - prev, 1);
                chk("R5 access count", acc_cnt - acc0, exp_len(info) + 2);
                drain_check(k, info, "R5 byte order");
            end
        end

        // R7 / R9 / R11: fill, wait on no room, exact fill to full
        info = 8'h08;
        ns = 0;
        for (int m = 0; m < 2; m++) begin
            load_msg(40 + m, info);
            prev = rel_cnt;
            @(negedge clk);
            pending = 1'b1;
            wait_release(prev);
            for (int j = 0; j < 11; j++) begin
                if (!(m == 0 && j == 0)) begin
                    seq[ns] = msg_byte(40 + m, j, info);
                    ns++;
                end
            end
            host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
            chk("R7 half flag after message", int'(q[5]), (m == 1) ? 1 : 0);
            chk("R7 not empty", int'(q[4]), 0);
        end
        load_msg(42, info);
        prev = rel_cnt;
        @(negedge clk);
        pending = 1'b1;
        repeat (40) @(negedge clk);
        chk("R9 held without room", rel_cnt - prev, 0);
        host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
        chk("R9 config served while waiting", lat, 1);
        host_acc(1'b0, 8'hFE, 8'h00, 1'b0, q, lat);
        chk("R9 first byte popped", int'(q), int'(info));
        wait_release(prev);
        chk("R9 released after room", rel_cnt - prev, 1);
        for (int j = 0; j < 11; j++) begin
            seq[ns] = msg_byte(42, j, info);
            ns++;
        end
        chk("R11 exactly full", ns, 32);
        for (int i = 0; i < 32; i++) begin
            host_acc(1'b0, 8'hFE, 8'h00, 1'b0, q, lat);
            chk("R11 stored whole in order", int'(q), int'(seq[i]));
            host_acc(1'b0, 8'hFF, 8'h00, 1'b0, q, lat);
            chk("R7 half flag at level", int'(q[5]), (31 - i >= 16) ? 1 : 0);
            chk("R7 empty flag at level", int'(q[4]), (i == 31) ? 1 : 0);
        end

        // R10: host controller access during a transfer waits for release
        info = 8'h88;
        load_msg(50, info);
        cmem[5] = 8'h3C;
        prev = rel_cnt;
        @(negedge clk);
        pending = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!(ctl_en && !ctl_we && ctl_addr == 8'd16) && lat < 100);
        host_acc(1'b0, 8'd5, 8'h00, 1'b0, q, lat);
        chk("R10 release before host access", rel_cnt - prev, 1);
        chk("R10 held access data", int'(q), 'h3C);
        chk("R10 held access was delayed", int'(lat > 2), 1);
        drain_check(50, info, "R10 transfer intact");

        // R10: host access and new interrupt together, host first
        info = 8'h02;
        load_msg(51, info);
        prev = rel_cnt;
        host_acc(1'b0, 8'd5, 8'h00, 1'b1, q, lat);
        chk("R10 host wins first slot", first_addr, 5);
        chk("R10 host read latency", lat, 2);
        wait_release(prev);
        drain_check(51, info, "R10 later transfer");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule